// File: doc/BRIEF.md
# Programmable Asynchronous Serial Adapter

This block is a byte-wide serial port that hangs off a simple register bus. One control byte configures it: how many system clocks make one bit time, which of eight character formats is on the wire, how the request-to-send line and transmit interrupt behave (or whether a continuous line break is sent), and whether received characters raise an interrupt. A status byte reports the receive and transmit holding states, the two modem inputs, three error conditions and the interrupt request itself.

The bus has one select line. With `bus_sel` low, a write goes to the control byte and a read returns status. With `bus_sel` high, a write hands a character to the transmitter and a read returns the last received character. `rd_data` is combinational; the side effects of a read take place on the clock edge where `rd_en` is high. There is no valid/ready handshake at the edge of this block. The transmit-empty status bit plays the part of ready for the transmit stream. A data write is always accepted, so a write while that bit is low replaces the waiting character. The receive-full bit plays the part of valid for the receive stream. A character that completes while it is still high is dropped and flagged.

Top module: `sio_adapter`

## Requirements
- R1: Control bits [1:0] set the bit time: code 00 is 1 clock, code 01 is 16 clocks and code 10 is 64 clocks per bit, on both transmit and receive.
- R2: Control bits [1:0] = 11 is the master-reset code. It is the value after `rst_n`. While it is held, status bits 0,1,2,4,5,6,7 read 0, `txd` idles high, data writes are ignored and nothing is received. Writing any other divider code starts operation.
- R3: Control bits [4:2] pick the format: 000 7 data/even/2 stop, 001 7/odd/2, 010 7/even/1, 011 7/odd/1, 100 8/none/2, 101 8/none/1, 110 8/even/1, 111 8/odd/1. A character goes out as one low start bit, the data LSB first, the parity bit if any, then high stop bits. A new character follows the last stop bit with no idle gap.
- R4: The parity bit makes the count of ones over data plus parity even (even formats) or odd (odd formats). A received 7-bit character reads back with bit 7 = 0.
- R5: Control bits [6:5] = 11 hold `txd` low for as long as the code stays, with `rts_n` low and no transmit interrupt.
- R6: `rts_n` is high only when control bits [6:5] = 10; codes 00, 01 and 11 drive it low.
- R7: When a received character's first stop bit has been sampled, the character becomes readable and status bit 0 (receive full) sets. A data read clears status bits 0, 4, 5 and 6.
- R8: Status bit 4 (framing error) sets when the first stop bit is sampled low.
- R9: Status bit 6 (parity error) sets when the received parity does not match the format.
- R10: A character that completes while status bit 0 is set raises status bit 5 (overrun). It is discarded and the older character stays readable.
- R11: A rising edge on `dcd_n` latches status bit 2 (carrier lost). Only a status read followed later by a data read clears it.
- R12: Status bit 1 (transmit empty) is high when no character waits for the transmitter and `cts_n` is low; it is forced low while `cts_n` is high. Status bit 3 reads the `cts_n` level.
- R13: `irq` and status bit 7 are high when control bit 7 is set and any of status bits 0, 5 or 2 is set, or when control bits [6:5] = 01 and status bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the master-reset code |
| bus_sel | input | 1 | 0: control (write) / status (read); 1: data |
| wr_en | input | 1 | Write strobe, one clock per access |
| rd_en | input | 1 | Read strobe; applies read side effects |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, selected by `bus_sel` |
| rxd | input | 1 | Serial receive line, idle high |
| cts_n | input | 1 | Clear-to-send, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| txd | output | 1 | Serial transmit line, idle high |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
A bad bit counter, divider count or frame shifter in the transmitter shows up on `txd` on the very clock where the line level is wrong. A behavioural model of the expected line level is checked against it every cycle, so such a fault shows within one bit time of the first character that uses it. A fault in receive sampling, parity or flag logic shows at the next status or data read after the affected character's first stop bit. Flag-clearing faults show at the read that follows the clearing access. Interrupt faults show on `irq` at the same negedge as the status change that should drive it.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int FRAME_MAX = 12;
  localparam logic [1:0] DIV_RESET = 2'b11;

  typedef struct packed {
    logic eight;     // 8 data bits when set, 7 otherwise
    logic par_en;    // parity bit present
    logic par_odd;   // odd parity when set
    logic two_stop;  // two stop bits when set
  } fmt_t;

  typedef enum logic [1:0] {
    TXC_PLAIN   = 2'b00,
    TXC_IRQ     = 2'b01,
    TXC_RTS_OFF = 2'b10,
    TXC_BREAK   = 2'b11
  } txc_e;

  function automatic fmt_t decode_fmt(input logic [2:0] code);
    fmt_t f;
    f.eight    = code[2];
    f.par_en   = ~code[2] | code[1];
    f.par_odd  = code[0];
    f.two_stop = ~code[1] & (~code[2] | ~code[0]);
    return f;
  endfunction

  function automatic logic [3:0] frame_len(input fmt_t f);
    return 4'd1 + (f.eight ? 4'd8 : 4'd7) + {3'd0, f.par_en} + (f.two_stop ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] div_sel,
  input  fmt_t       fmt,
  input  logic       brk,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  output logic       hold_full,
  output logic       txd
);

  localparam int CNT_W = $clog2(DIV_HI);

  logic [7:0]           hold_q;
  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [3:0]           left_q;
  logic [FRAME_MAX-1:0] sr_q;
  logic [FRAME_MAX-1:0] frame_w;
  logic [CNT_W-1:0]     div_lim;
  logic                 par_bit;
  logic                 bit_end;
  logic                 last_bit;

  always_comb begin
    case (div_sel)
      2'b01:   div_lim = CNT_W'(DIV_MID - 1);
      2'b10:   div_lim = CNT_W'(DIV_HI - 1);
      default: div_lim = '0;
    endcase
  end

  // Serial image of the waiting character, start bit in position 0
  always_comb begin
    frame_w      = '1;
    frame_w[0]   = 1'b0;
    frame_w[7:1] = hold_q[6:0];
    if (fmt.eight) frame_w[8] = hold_q[7];
    par_bit = (^(hold_q & (fmt.eight ? 8'hFF : 8'h7F))) ^ fmt.par_odd;
    if (fmt.par_en) begin
      if (fmt.eight) frame_w[9] = par_bit;
      else           frame_w[8] = par_bit;
    end
  end

  assign bit_end  = busy_q && (cnt_q == div_lim);
  assign last_bit = bit_end && (left_q == 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      left_q    <= '0;
      sr_q      <= '1;
    end else if (!active) begin
      hold_full <= 1'b0;
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      left_q    <= '0;
      sr_q      <= '1;
    end else begin
      if (bit_end) begin
        cnt_q  <= '0;
        sr_q   <= {1'b1, sr_q[FRAME_MAX-1:1]};
        left_q <= left_q - 4'd1;
        if (left_q == 4'd1) busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if ((!busy_q || last_bit) && hold_full) begin
        busy_q    <= 1'b1;
        sr_q      <= frame_w;
        left_q    <= frame_len(fmt);
        cnt_q     <= '0;
        hold_full <= 1'b0;
      end
      if (wr_stb) begin
        hold_q    <= wr_byte;
        hold_full <= 1'b1;
      end
    end
  end

  assign txd = !active ? 1'b1 : (brk ? 1'b0 : (busy_q ? sr_q[0] : 1'b1));

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (sr_q[0] == 1'b0));

  // R2
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!busy_q && !hold_full));

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] div_sel,
  input  logic       eight,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       rxd,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       par_err,
  output logic       frm_err
);

  localparam int CNT_W    = $clog2(DIV_HI);
  localparam int HALF_MID = DIV_MID / 2;
  localparam int HALF_HI  = DIV_HI / 2;

  logic             run_q;
  logic [3:0]       idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q;
  logic             acc_q;
  logic [CNT_W-1:0] div_lim;
  logic [CNT_W-1:0] half_lim;
  logic [3:0]       data_n;
  logic [3:0]       par_pos;

  always_comb begin
    case (div_sel)
      2'b01:   begin div_lim = CNT_W'(DIV_MID - 1); half_lim = CNT_W'(HALF_MID - 1); end
      2'b10:   begin div_lim = CNT_W'(DIV_HI - 1);  half_lim = CNT_W'(HALF_HI - 1);  end
      default: begin div_lim = '0;                  half_lim = '0;                   end
    endcase
  end

  assign data_n  = eight ? 4'd8 : 4'd7;
  assign par_pos = data_n + 4'd1;

  // Position 0 is the start bit, 1..data_n data, then parity, then stop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      idx_q   <= '0;
      cnt_q   <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
    end else if (!active) begin
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run_q) begin
        if (!rxd) begin
          run_q <= 1'b1;
          acc_q <= 1'b0;
          if (div_sel == 2'b00) begin
            cnt_q <= '0;
            idx_q <= 4'd1;
          end else begin
            cnt_q <= half_lim;
            idx_q <= 4'd0;
          end
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        cnt_q <= div_lim;
        idx_q <= idx_q + 4'd1;
        if (idx_q == 4'd0) begin
          if (rxd) run_q <= 1'b0;
        end else if (idx_q <= data_n) begin
          sh_q  <= {rxd, sh_q[7:1]};
          acc_q <= acc_q ^ rxd;
        end else if (par_en && (idx_q == par_pos)) begin
          acc_q <= acc_q ^ rxd;
        end else begin
          run_q   <= 1'b0;
          done    <= 1'b1;
          frm_err <= !rxd;
          par_err <= par_en & (acc_q ^ par_odd);
          rx_byte <= eight ? sh_q : {1'b0, sh_q[7:1]};
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/sio_adapter.sv
module sio_adapter
  import sio_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       rxd,
  input  logic       cts_n,
  input  logic       dcd_n,
  output logic       txd,
  output logic       rts_n,
  output logic       irq
);

  logic [7:0] ctrl_q;
  logic       active;
  fmt_t       fmt;
  txc_e       txc;
  logic       rx_ie;
  logic       tx_ie;

  logic       hold_full;
  logic       rx_done;
  logic [7:0] rx_byte;
  logic       rx_perr;
  logic       rx_ferr;

  logic [7:0] rx_hold_q;
  logic       rdrf_q;
  logic       ovr_q;
  logic       pe_q;
  logic       fe_q;
  logic       lost_q;
  logic       stat_seen_q;
  logic       dcd_q;
  logic       tdre;
  logic       data_rd;
  logic       stat_rd;
  logic [7:0] status;

  assign active  = (ctrl_q[1:0] != DIV_RESET);
  assign fmt     = decode_fmt(ctrl_q[4:2]);
  assign txc     = txc_e'(ctrl_q[6:5]);
  assign rx_ie   = ctrl_q[7];
  assign tx_ie   = (txc == TXC_IRQ);
  assign data_rd = rd_en && bus_sel;
  assign stat_rd = rd_en && !bus_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= {6'd0, DIV_RESET};
    else if (wr_en && !bus_sel) ctrl_q <= wr_data;
  end

  sio_tx #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .div_sel  (ctrl_q[1:0]),
    .fmt      (fmt),
    .brk      (txc == TXC_BREAK),
    .wr_stb   (wr_en && bus_sel && active),
    .wr_byte  (wr_data),
    .hold_full(hold_full),
    .txd      (txd)
  );

  sio_rx #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_rx (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (active),
    .div_sel(ctrl_q[1:0]),
    .eight  (fmt.eight),
    .par_en (fmt.par_en),
    .par_odd(fmt.par_odd),
    .rxd    (rxd),
    .done   (rx_done),
    .rx_byte(rx_byte),
    .par_err(rx_perr),
    .frm_err(rx_ferr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_hold_q   <= '0;
      rdrf_q      <= 1'b0;
      ovr_q       <= 1'b0;
      pe_q        <= 1'b0;
      fe_q        <= 1'b0;
      lost_q      <= 1'b0;
      stat_seen_q <= 1'b0;
      dcd_q       <= 1'b0;
    end else begin
      dcd_q <= dcd_n;
      if (!active) begin
        rdrf_q      <= 1'b0;
        ovr_q       <= 1'b0;
        pe_q        <= 1'b0;
        fe_q        <= 1'b0;
        lost_q      <= 1'b0;
        stat_seen_q <= 1'b0;
      end else begin
        if (stat_rd && lost_q) stat_seen_q <= 1'b1;
        if (data_rd) begin
          rdrf_q <= 1'b0;
          ovr_q  <= 1'b0;
          pe_q   <= 1'b0;
          fe_q   <= 1'b0;
          if (stat_seen_q) begin
            lost_q      <= 1'b0;
            stat_seen_q <= 1'b0;
          end
        end
        if (rx_done) begin
          if (rdrf_q && !data_rd) begin
            ovr_q <= 1'b1;
          end else begin
            rx_hold_q <= rx_byte;
            rdrf_q    <= 1'b1;
            pe_q      <= rx_perr;
            fe_q      <= rx_ferr;
          end
        end
        if (dcd_n && !dcd_q) lost_q <= 1'b1;
      end
    end
  end

  assign tdre    = active && !hold_full && !cts_n;
  assign irq     = active && ((rx_ie && (rdrf_q || ovr_q || lost_q)) || (tx_ie && tdre));
  assign rts_n   = (txc == TXC_RTS_OFF);
  assign status  = {irq, pe_q, ovr_q, fe_q, cts_n, lost_q, tdre, rdrf_q};
  assign rd_data = bus_sel ? rx_hold_q : status;

  // R10
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && rx_done && rdrf_q && !data_rd) |=> (ovr_q && $stable(rx_hold_q)));

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && data_rd && !rx_done) |=> (!rdrf_q && !ovr_q && !pe_q && !fe_q));

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!rdrf_q && !ovr_q && !lost_q));

  // R11
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && dcd_n && !dcd_q) |=> lost_q);

endmodule

// File: tb/tb_sio_adapter.sv
`timescale 1ns/1ps
module tb_sio_adapter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cts_n = 1'b0;
  logic       dcd_n = 1'b0;
  logic       loop_en = 1'b1;
  logic       rx_force = 1'b1;
  logic       txd;
  logic       rts_n;
  logic       irq;
  logic       rxd;

  assign rxd = loop_en ? txd : rx_force;

  always #2.5 clk = ~clk;

  sio_adapter dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .cts_n(cts_n), .dcd_n(dcd_n),
    .txd(txd), .rts_n(rts_n), .irq(irq)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ---------------- behavioural line model ----------------
  logic [7:0] m_ctrl;
  bit         m_wd;
  logic [7:0] m_wb;
  bit         q[$];

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'b01) ? 16 : ((c == 2'b10) ? 64 : 1);
  endfunction

  task automatic push_bits(input bit b, input int n);
    for (int k = 0; k < n; k++) q.push_back(b);
  endtask

  task automatic push_frame(input logic [7:0] d);
    int n;
    int dbits;
    int stops;
    bit has_par;
    bit p;
    logic [2:0] f;
    n = div_of(m_ctrl[1:0]);
    f = m_ctrl[4:2];
    dbits = f[2] ? 8 : 7;
    has_par = !f[2] || f[1];
    stops = (f == 3'd0 || f == 3'd1 || f == 3'd4) ? 2 : 1;
    p = f[0];
    push_bits(1'b0, n);
    for (int i = 0; i < dbits; i++) begin
      push_bits(d[i], n);
      p = p ^ d[i];
    end
    if (has_par) push_bits(p, n);
    for (int s = 0; s < stops; s++) push_bits(1'b1, n);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl <= 8'h03;
      m_wd   <= 1'b0;
    end else begin
      m_wd <= wr_en && bus_sel && (m_ctrl[1:0] != 2'b11);
      m_wb <= wr_data;
      if (wr_en && !bus_sel) m_ctrl <= wr_data;
    end
  end

  always @(negedge clk) begin
    bit lvl;
    if (!rst_n) begin
      q.delete();
    end else begin
      if (m_ctrl[1:0] == 2'b11) q.delete();
      lvl = (q.size() > 0) ? q.pop_front() : 1'b1;
      if (m_ctrl[1:0] == 2'b11)      lvl = 1'b1;
      else if (m_ctrl[6:5] == 2'b11) lvl = 1'b0;
      chk(txd === lvl, "R1 R3 txd level vs model", int'(txd), int'(lvl));
      if (m_wd) push_frame(m_wb);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input bit sel, output logic [7:0] v);
    @(negedge clk);
    bus_sel = sel; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b0;
    #1 v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rdrf();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      bus_sel = 1'b0;
      #1;
      if (rd_data[0]) return;
    end
    chk(1'b0, "R7 receive full never set", 0, 1);
  endtask

  task automatic send_raw(input logic [7:0] d, input bit par, input bit stop);
    @(negedge clk); rx_force = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_force = d[i];
    end
    @(negedge clk); rx_force = par;
    @(negedge clk); rx_force = stop;
    @(negedge clk); rx_force = 1'b1;
  endtask

  task automatic measure_low(input int exp_n, input string tag);
    int cnt;
    cnt = 0;
    wr(1'b1, 8'hFF);
    for (int k = 0; k < 500 && txd; k++) @(negedge clk);
    while (!txd && cnt < 500) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt == exp_n, tag, cnt, exp_n);
    idle(800);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_up();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] b;
    logic [7:0] c;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: state after reset
    peek(v);
    chk(v == 8'h00, "R2 status after reset", v, 8'h00);
    chk(txd == 1'b1, "R2 txd idle after reset", txd, 1);
    chk(rts_n == 1'b0, "R6 rts_n after reset", rts_n, 0);

    // R2: data write ignored in master reset
    wr(1'b1, 8'hA5);
    idle(30);
    peek(v);
    chk(v[1] == 1'b0, "R2 transmit empty held low in reset", v[1], 0);

    // leave reset: 8N1, divide by 1; nothing queued from the ignored write
    wr(1'b0, 8'h14);
    peek(v);
    chk(v == 8'h02, "R12 status after start", v, 8'h02);
    idle(30);

    // R3 R4 R7 R1: loopback through all eight formats
    for (int i = 0; i < 8; i++) begin
      c = {3'b000, 3'(i), 2'(i % 3)};
      b = 8'h3C ^ 8'(i * 37);
      wr(1'b0, c);
      wr(1'b1, b);
      wait_rdrf();
      rd(1'b0, v);
      chk((v & 8'h71) == 8'h01, "R4 R7 status after loopback", v & 8'h71, 8'h01);
      rd(1'b1, v);
      chk(v == (c[4] ? b : (b & 8'h7F)), "R3 R4 loopback character", v, c[4] ? b : (b & 8'h7F));
      peek(v);
      chk(v[0] == 1'b0, "R7 receive full cleared by data read", v[0], 0);
      idle(150);
    end

    // R10: overrun keeps the older character
    wr(1'b0, 8'h14);
    wr(1'b1, 8'h5A);
    idle(3);
    wr(1'b1, 8'hC3);
    idle(40);
    rd(1'b0, v);
    chk((v & 8'h71) == 8'h21, "R10 overrun flagged", v & 8'h71, 8'h21);
    rd(1'b1, v);
    chk(v == 8'h5A, "R10 older character kept", v, 8'h5A);
    peek(v);
    chk((v & 8'h71) == 8'h00, "R7 flags cleared after read", v & 8'h71, 8'h00);
    idle(20);

    // R9: injected parity error, 8 data even parity, divide by 1
    loop_en = 1'b0;
    rx_force = 1'b1;
    wr(1'b0, 8'h18);
    send_raw(8'h33, 1'b1, 1'b1);
    idle(5);
    rd(1'b0, v);
    chk((v & 8'h71) == 8'h41, "R9 parity error flagged", v & 8'h71, 8'h41);
    rd(1'b1, v);
    chk(v == 8'h33, "R9 character with parity error", v, 8'h33);

    // R8: injected framing error
    send_raw(8'h81, 1'b0, 1'b0);
    idle(5);
    rd(1'b0, v);
    chk((v & 8'h71) == 8'h11, "R8 framing error flagged", v & 8'h71, 8'h11);
    rd(1'b1, v);
    chk(v == 8'h81, "R8 character with framing error", v, 8'h81);

    // R5: continuous break
    wr(1'b0, 8'h74);
    idle(20);
    chk(txd == 1'b0, "R5 txd held low in break", txd, 0);
    chk(rts_n == 1'b0, "R5 rts_n low in break", rts_n, 0);
    // R6
    wr(1'b0, 8'h54);
    idle(2);
    chk(rts_n == 1'b1, "R6 rts_n high in code 10", rts_n, 1);
    chk(txd == 1'b1, "R5 txd idle after break", txd, 1);
    wr(1'b0, 8'h14);
    idle(2);
    chk(rts_n == 1'b0, "R6 rts_n low in code 00", rts_n, 0);

    // R12: clear-to-send gating
    cts_n = 1'b1;
    peek(v);
    chk(v[1] == 1'b0, "R12 empty forced low by cts_n", v[1], 0);
    chk(v[3] == 1'b1, "R12 cts_n reported", v[3], 1);
    cts_n = 1'b0;
    peek(v);
    chk(v[1] == 1'b1 && v[3] == 1'b0, "R12 empty with cts_n low", {v[3], v[1]}, 1);

    // R13: transmit interrupt
    wr(1'b0, 8'h34);
    peek(v);
    chk(irq == 1'b1 && v[7] == 1'b1, "R13 transmit irq", {irq, v[7]}, 3);
    cts_n = 1'b1;
    peek(v);
    chk(irq == 1'b0, "R13 transmit irq drops with cts_n", irq, 0);
    cts_n = 1'b0;

    // R13: receive interrupt
    wr(1'b0, 8'h94);
    loop_en = 1'b1;
    peek(v);
    chk(irq == 1'b0, "R13 no irq without receive", irq, 0);
    wr(1'b1, 8'h42);
    wait_rdrf();
    chk(irq == 1'b1, "R13 receive irq", irq, 1);
    rd(1'b1, v);
    chk(v == 8'h42, "R7 received character", v, 8'h42);
    peek(v);
    chk(irq == 1'b0, "R13 irq cleared by data read", irq, 0);
    idle(20);

    // R11: carrier lost latch and clearing order
    dcd_n = 1'b1;
    idle(3);
    peek(v);
    chk(v[2] == 1'b1 && irq == 1'b1, "R11 carrier lost set with irq", {v[2], irq}, 3);
    rd(1'b1, v);
    peek(v);
    chk(v[2] == 1'b1, "R11 data read alone does not clear", v[2], 1);
    rd(1'b0, v);
    rd(1'b1, v);
    peek(v);
    chk(v[2] == 1'b0, "R11 cleared by status then data read", v[2], 0);
    dcd_n = 1'b0;
    idle(3);
    peek(v);
    chk(v[2] == 1'b0 && irq == 1'b0, "R11 falling dcd_n sets nothing", {v[2], irq}, 0);

    // R1: bit time in the slower modes
    loop_en = 1'b0;
    rx_force = 1'b1;
    wr(1'b0, 8'h15);
    measure_low(16, "R1 start bit width divide 16");
    wr(1'b0, 8'h16);
    measure_low(64, "R1 start bit width divide 64");

    // R2: master reset clears latched flags
    loop_en = 1'b1;
    wr(1'b0, 8'h14);
    idle(5);
    wr(1'b1, 8'h77);
    wait_rdrf();
    idle(10);
    wr(1'b0, 8'h03);
    peek(v);
    chk(v == 8'h00, "R2 master reset clears status", v, 8'h00);
    chk(txd == 1'b1, "R2 txd idle in master reset", txd, 1);
    wr(1'b0, 8'h14);
    peek(v);
    chk(v == 8'h02, "R2 restart with empty receiver", v, 8'h02);
    idle(20);

    finish_up();
  end

endmodule